// File: doc/BRIEF.md
# Bit-Serial Early-Pruning Dot-Product Lane

This lane scores one key token against a query vector without necessarily reading the whole key. The key arrives one bit-plane per transfer, starting with the sign plane. Each plane is a mask that has one bit per query element. The lane adds up the query elements that the mask selects and scales that sum by the weight of the plane. The result goes into a per-token running-sum entry.

After each plane the lane forms two bounds on the final score. The planes still to come can only add positive weight. The largest possible remaining contribution is therefore the sum of the positive query elements times the total weight left. The smallest is the sum of the negative query elements times that same weight. A threshold comes from outside the lane. When the upper bound does not exceed the threshold, the lane flags the token for pruning so that no further planes are fetched for it. A token that reaches the last plane unpruned is flagged as kept, and its exact score is reported.

A two-state controller handles the plane input. In ST_TAKE the lane is ready. Accepting a plane is the transition "accept", and it moves the controller to ST_SHOW. In ST_SHOW the result registers are presented for one cycle, and the transition "report done" returns the controller to ST_TAKE. When no plane is offered, ST_TAKE holds through the transition "idle".

Top module: `bsl_lane`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `plane_ready` is 1 and `res_valid` is 0.
- R2: When a plane is accepted (`plane_valid` and `plane_ready` high at a rising edge), `res_valid` is 1 for exactly the next cycle. `plane_ready` is 0 during that cycle, and a plane offered in that cycle is not taken.
- R3: Bit i of `plane_bits` selects query element i, which sits at `query_flat[12i+11:12i]` as a signed value. Round 0 carries weight −2048. Round r (1..11) carries weight +2^(11−r).
- R4: A plane with round 0 starts a fresh entry for its token. A plane with any later round adds its contribution to the entry that token already holds. `res_psum` reports the updated entry.
- R5: Each token index keeps its own entry. Planes for one token leave the entries of all other tokens unchanged.
- R6: `res_upper` equals `res_psum` + P·(2^(11−r) − 1), where P is the sum of the positive query elements.
- R7: `res_lower` equals `res_psum` + N·(2^(11−r) − 1), where N is the sum of the negative query elements.
- R8: `res_prune` is 1 exactly when `res_upper` is less than or equal to the signed `threshold`.
- R9: After round 11 both bounds equal `res_psum`, which is the exact dot product. `res_keep` is 1 exactly when the round is 11 and the token is not pruned.
- R10: The running sum and the bounds are exact for every extreme input, including all elements at −2048 or at +2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| query_flat | input | 192 | Sixteen signed 12-bit query elements; element i at bits 12i+11:12i |
| plane_valid | input | 1 | A key bit-plane is offered |
| plane_ready | output | 1 | Lane can take a plane this cycle |
| plane_bits | input | 16 | One key bit per query element for this plane |
| plane_token | input | 3 | Token index of the plane |
| plane_round | input | 4 | Plane number, 0 = sign plane, 11 = least significant |
| threshold | input | 32 | Signed pruning threshold |
| res_valid | output | 1 | Result registers hold a fresh result |
| res_token | output | 3 | Token index of the result |
| res_round | output | 4 | Round of the result |
| res_psum | output | 32 | Updated running sum |
| res_upper | output | 32 | Upper bound on the final score |
| res_lower | output | 32 | Lower bound on the final score |
| res_prune | output | 1 | Stop fetching planes for this token |
| res_keep | output | 1 | Token survived all planes |

## Verification
The bench sets the threshold exactly equal to the upper bound and then one below it. A lane that compares strictly, or the wrong way, gives the wrong decision at one of these two points. Two tokens are interleaved, and one of them is then restarted at round 0. A lane that shares a single entry, or that fails to clear the entry on round 0, reports sums mixed from the wrong planes. Extreme query and key values check the sign-plane weight and the width of the sum. A plane left offered during the report cycle exposes a lane that counts it twice.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
    localparam int unsigned N_ELEM_D   = 16;
    localparam int unsigned Q_BITS_D   = 12;
    localparam int unsigned KEY_BITS_D = 12;
    localparam int unsigned ACC_BITS_D = 32;
    localparam int unsigned N_TOK_D    = 8;

    typedef enum logic [0:0] {
        ST_TAKE = 1'b0,
        ST_SHOW = 1'b1
    } lane_state_e;
endpackage

// File: rtl/bsl_plane_dot.sv
module bsl_plane_dot #(
    parameter int unsigned N_ELEM = 16,
    parameter int unsigned Q_BITS = 12,
    parameter int unsigned DOT_W  = Q_BITS + $clog2(N_ELEM) + 1
) (
    input  logic [N_ELEM*Q_BITS-1:0] query_flat,
    input  logic [N_ELEM-1:0]        mask,
    output logic signed [DOT_W-1:0]  dot
);
    logic signed [DOT_W-1:0] term [N_ELEM];

    for (genvar gi = 0; gi < N_ELEM; gi++) begin : g_term
        logic signed [Q_BITS-1:0] elem;
        assign elem     = query_flat[gi*Q_BITS +: Q_BITS];
        assign term[gi] = mask[gi] ? DOT_W'(elem) : '0;
    end

    always_comb begin
        dot = '0;
        for (int i = 0; i < N_ELEM; i++) begin
            dot = dot + term[i];
        end
    end
endmodule

// File: rtl/bsl_margin_lut.sv
module bsl_margin_lut #(
    parameter int unsigned N_ELEM   = 16,
    parameter int unsigned Q_BITS   = 12,
    parameter int unsigned KEY_BITS = 12,
    parameter int unsigned ACC_BITS = 32,
    parameter int unsigned RND_W    = $clog2(KEY_BITS),
    parameter int unsigned DOT_W    = Q_BITS + $clog2(N_ELEM) + 1
) (
    input  logic [N_ELEM*Q_BITS-1:0]   query_flat,
    input  logic [RND_W-1:0]           round,
    output logic signed [ACC_BITS-1:0] max_rem,
    output logic signed [ACC_BITS-1:0] min_rem
);
    logic signed [DOT_W-1:0]    pos_sum;
    logic signed [DOT_W-1:0]    neg_sum;
    logic signed [ACC_BITS-1:0] hi_tab [KEY_BITS];
    logic signed [ACC_BITS-1:0] lo_tab [KEY_BITS];

    always_comb begin
        pos_sum = '0;
        neg_sum = '0;
        for (int i = 0; i < N_ELEM; i++) begin
            if (query_flat[i*Q_BITS + Q_BITS - 1])
                neg_sum = neg_sum + DOT_W'($signed(query_flat[i*Q_BITS +: Q_BITS]));
            else
                pos_sum = pos_sum + DOT_W'($signed(query_flat[i*Q_BITS +: Q_BITS]));
        end
    end

    // Table of remaining-weight margins, one entry per round: sum * (2^sh - 1)
    for (genvar gr = 0; gr < KEY_BITS; gr++) begin : g_tab
        localparam int unsigned SH = KEY_BITS - 1 - gr;
        assign hi_tab[gr] = (ACC_BITS'(pos_sum) <<< SH) - ACC_BITS'(pos_sum);
        assign lo_tab[gr] = (ACC_BITS'(neg_sum) <<< SH) - ACC_BITS'(neg_sum);
    end

    always_comb begin
        max_rem = '0;
        min_rem = '0;
        for (int r = 0; r < KEY_BITS; r++) begin
            if (round == RND_W'(r)) begin
                max_rem = hi_tab[r];
                min_rem = lo_tab[r];
            end
        end
    end
endmodule

// File: rtl/bsl_scoreboard.sv
module bsl_scoreboard #(
    parameter int unsigned N_TOK    = 8,
    parameter int unsigned ACC_BITS = 32,
    parameter int unsigned TOK_W    = $clog2(N_TOK)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [TOK_W-1:0]           rd_idx,
    output logic signed [ACC_BITS-1:0] rd_data,
    input  logic                       wr_en,
    input  logic [TOK_W-1:0]           wr_idx,
    input  logic signed [ACC_BITS-1:0] wr_data
);
    logic signed [ACC_BITS-1:0] entry [N_TOK];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < N_TOK; t++) entry[t] <= '0;
        end else if (wr_en) begin
            entry[wr_idx] <= wr_data;
        end
    end

    assign rd_data = entry[rd_idx];
endmodule

// File: rtl/bsl_lane.sv
module bsl_lane
    import bsl_pkg::*;
#(
    parameter int unsigned N_ELEM   = N_ELEM_D,
    parameter int unsigned Q_BITS   = Q_BITS_D,
    parameter int unsigned KEY_BITS = KEY_BITS_D,
    parameter int unsigned ACC_BITS = ACC_BITS_D,
    parameter int unsigned N_TOK    = N_TOK_D,
    localparam int unsigned TOK_W   = $clog2(N_TOK),
    localparam int unsigned RND_W   = $clog2(KEY_BITS),
    localparam int unsigned DOT_W   = Q_BITS + $clog2(N_ELEM) + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_ELEM*Q_BITS-1:0]   query_flat,
    input  logic                       plane_valid,
    output logic                       plane_ready,
    input  logic [N_ELEM-1:0]          plane_bits,
    input  logic [TOK_W-1:0]           plane_token,
    input  logic [RND_W-1:0]           plane_round,
    input  logic signed [ACC_BITS-1:0] threshold,
    output logic                       res_valid,
    output logic [TOK_W-1:0]           res_token,
    output logic [RND_W-1:0]           res_round,
    output logic signed [ACC_BITS-1:0] res_psum,
    output logic signed [ACC_BITS-1:0] res_upper,
    output logic signed [ACC_BITS-1:0] res_lower,
    output logic                       res_prune,
    output logic                       res_keep
);
    localparam logic [RND_W-1:0] LAST_RND = RND_W'(KEY_BITS - 1);

    lane_state_e state_q, state_d;
    logic        accept;

    logic signed [DOT_W-1:0]    plane_dot;
    logic signed [ACC_BITS-1:0] dot_ext;
    logic signed [ACC_BITS-1:0] contrib;
    logic signed [ACC_BITS-1:0] prior;
    logic signed [ACC_BITS-1:0] sb_rd;
    logic signed [ACC_BITS-1:0] new_psum;
    logic signed [ACC_BITS-1:0] max_rem, min_rem;
    logic signed [ACC_BITS-1:0] new_upper, new_lower;
    logic [RND_W-1:0]           shamt;

    bsl_plane_dot #(.N_ELEM(N_ELEM), .Q_BITS(Q_BITS), .DOT_W(DOT_W)) i_dot (
        .query_flat (query_flat),
        .mask       (plane_bits),
        .dot        (plane_dot)
    );

    bsl_margin_lut #(
        .N_ELEM(N_ELEM), .Q_BITS(Q_BITS), .KEY_BITS(KEY_BITS),
        .ACC_BITS(ACC_BITS), .RND_W(RND_W), .DOT_W(DOT_W)
    ) i_margin (
        .query_flat (query_flat),
        .round      (plane_round),
        .max_rem    (max_rem),
        .min_rem    (min_rem)
    );

    bsl_scoreboard #(.N_TOK(N_TOK), .ACC_BITS(ACC_BITS), .TOK_W(TOK_W)) i_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (plane_token),
        .rd_data (sb_rd),
        .wr_en   (accept),
        .wr_idx  (plane_token),
        .wr_data (new_psum)
    );

    // Plane arithmetic
    always_comb begin
        dot_ext = ACC_BITS'(plane_dot);
        shamt   = LAST_RND - plane_round;
        if (plane_round == '0) begin
            contrib = -(dot_ext <<< LAST_RND);
            prior   = '0;
        end else begin
            contrib = dot_ext <<< shamt;
            prior   = sb_rd;
        end
        new_psum  = prior + contrib;
        new_upper = new_psum + max_rem;
        new_lower = new_psum + min_rem;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_TAKE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TAKE: if (plane_valid) state_d = ST_SHOW;   // accept
            ST_SHOW: state_d = ST_TAKE;                     // report done
            default: state_d = ST_TAKE;
        endcase
    end

    // Outputs of the controller
    always_comb begin
        plane_ready = 1'b0;
        res_valid   = 1'b0;
        unique case (state_q)
            ST_TAKE: plane_ready = 1'b1;
            ST_SHOW: res_valid   = 1'b1;
            default: ;
        endcase
    end

    assign accept = plane_valid && plane_ready;

    // Result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_token <= '0;
            res_round <= '0;
            res_psum  <= '0;
            res_upper <= '0;
            res_lower <= '0;
            res_prune <= 1'b0;
            res_keep  <= 1'b0;
        end else if (accept) begin
            res_token <= plane_token;
            res_round <= plane_round;
            res_psum  <= new_psum;
            res_upper <= new_upper;
            res_lower <= new_lower;
            res_prune <= (new_upper <= threshold);
            res_keep  <= (new_upper > threshold) && (plane_round == LAST_RND);
        end
    end

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    a_r2_accept_then_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (plane_valid && plane_ready) |=> res_valid);
    a_r2_busy_while_showing: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !plane_ready);
    a_r3_round_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (plane_valid && plane_ready) |-> (plane_round <= LAST_RND));
    a_r10_upper_not_below: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_upper >= res_psum && res_lower <= res_psum));
    a_r9_last_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_round == LAST_RND) |-> (res_upper == res_psum && res_lower == res_psum));
    a_r8_decision_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !(res_prune && res_keep));
    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && !(plane_valid && plane_ready)) |=> $stable(res_psum));
endmodule

// File: tb/test_bsl_lane.sv
module test_bsl_lane;
    localparam time CLK_PERIOD = 10ns;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [191:0]       query_flat;
    logic               plane_valid;
    logic               plane_ready;
    logic [15:0]        plane_bits;
    logic [2:0]         plane_token;
    logic [3:0]         plane_round;
    logic signed [31:0] threshold;
    logic               res_valid;
    logic [2:0]         res_token;
    logic [3:0]         res_round;
    logic signed [31:0] res_psum, res_upper, res_lower;
    logic               res_prune, res_keep;

    int checks = 0;
    int errors = 0;

    logic signed [11:0] q  [16];
    logic signed [11:0] ka [16];
    logic signed [11:0] kb [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    bsl_lane i_bsl_lane (
        .clk(clk), .rst_n(rst_n), .query_flat(query_flat),
        .plane_valid(plane_valid), .plane_ready(plane_ready),
        .plane_bits(plane_bits), .plane_token(plane_token),
        .plane_round(plane_round), .threshold(threshold),
        .res_valid(res_valid), .res_token(res_token), .res_round(res_round),
        .res_psum(res_psum), .res_upper(res_upper), .res_lower(res_lower),
        .res_prune(res_prune), .res_keep(res_keep)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic load_query();
        for (int i = 0; i < 16; i++) query_flat[i*12 +: 12] = q[i];
    endtask

    function automatic logic [15:0] bits_of(input logic signed [11:0] k [16], input int r);
        logic [15:0] b;
        for (int i = 0; i < 16; i++) b[i] = k[i][11-r];
        return b;
    endfunction

    function automatic longint exp_psum(input logic signed [11:0] k [16], input int r);
        longint s = 0;
        for (int i = 0; i < 16; i++) begin
            longint kv = longint'(k[i]);
            kv = (kv >>> (11 - r)) <<< (11 - r);
            s += longint'(q[i]) * kv;
        end
        return s;
    endfunction

    function automatic longint margin(input bit positive, input int r);
        longint s = 0;
        for (int i = 0; i < 16; i++)
            if ((q[i] > 0) == positive && q[i] != 0) s += longint'(q[i]);
        return s * ((longint'(1) <<< (11 - r)) - 1);
    endfunction

    task automatic send(input int tok, input int rnd, input logic [15:0] bits, input longint thr);
        @(negedge clk);
        plane_valid = 1'b1;
        plane_bits  = bits;
        plane_token = 3'(tok);
        plane_round = 4'(rnd);
        threshold   = 32'(thr);
        @(posedge clk);
        @(negedge clk);
        plane_valid = 1'b0;
    endtask

    task automatic check_bounds(input string req, input logic signed [11:0] k [16], input int r);
        longint p = exp_psum(k, r);
        chk(req, "psum", res_psum, p);
        chk("R6", "upper", res_upper, p + margin(1'b1, r));
        chk("R7", "lower", res_lower, p + margin(1'b0, r));
    endtask

    task automatic run_token(input string req, input int tok, input logic signed [11:0] k [16]);
        longint dot = exp_psum(k, 11);
        for (int r = 0; r < 12; r++) begin
            send(tok, r, bits_of(k, r), -64'sd2147483648);
            check_bounds(req, k, r);
            chk("R8", "prune low thr", res_prune, 0);
            chk("R9", "keep", res_keep, (r == 11) ? 1 : 0);
        end
        chk("R9", "final exact", res_psum, dot);
        chk("R9", "upper at end", res_upper, dot);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; plane_valid = 1'b0; plane_bits = '0; plane_token = '0;
        plane_round = '0; threshold = '0; query_flat = '0;
        repeat (3) @(negedge clk);
        chk("R1", "ready in reset", plane_ready, 1);
        chk("R1", "valid in reset", res_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready after reset", plane_ready, 1);
        chk("R1", "valid after reset", res_valid, 0);
    endtask

    task automatic t_full_keep();
        for (int i = 0; i < 16; i++) begin
            q[i]  = 12'(i * 733 + 101);
            ka[i] = 12'(i * 1291 + 57);
            kb[i] = 12'(i * 2039 + 1500);
        end
        load_query();
        run_token("R3", 1, ka);
        run_token("R4", 4, kb);
    endtask

    task automatic t_prune_high();
        send(0, 0, bits_of(ka, 0), 64'sd2147483647);
        chk("R8", "prune high thr", res_prune, 1);
        chk("R9", "no keep when pruned", res_keep, 0);
    endtask

    task automatic t_threshold_edge();
        longint up0 = exp_psum(ka, 0) + margin(1'b1, 0);
        longint dot = exp_psum(ka, 11);
        send(3, 0, bits_of(ka, 0), up0);
        chk("R8", "thr equal upper", res_prune, 1);
        send(3, 0, bits_of(ka, 0), up0 - 1);
        chk("R8", "thr below upper", res_prune, 0);
        for (int r = 1; r < 11; r++) send(3, r, bits_of(ka, r), -64'sd2147483648);
        send(3, 11, bits_of(ka, 11), dot);
        chk("R9", "final equal thr prunes", res_prune, 1);
        chk("R9", "final equal thr keep", res_keep, 0);
        send(3, 0, bits_of(ka, 0), -64'sd2147483648);
        for (int r = 1; r < 11; r++) send(3, r, bits_of(ka, r), -64'sd2147483648);
        send(3, 11, bits_of(ka, 11), dot - 1);
        chk("R9", "final above thr keep", res_keep, 1);
    endtask

    task automatic t_interleave();
        for (int r = 0; r < 4; r++) begin
            send(2, r, bits_of(ka, r), -64'sd2147483648);
            chk("R5", "token 2 psum", res_psum, exp_psum(ka, r));
            chk("R5", "token id", res_token, 2);
            send(5, r, bits_of(kb, r), -64'sd2147483648);
            chk("R5", "token 5 psum", res_psum, exp_psum(kb, r));
            chk("R5", "round id", res_round, r);
        end
        send(2, 0, bits_of(kb, 0), -64'sd2147483648);
        chk("R4", "restart clears entry", res_psum, exp_psum(kb, 0));
        send(5, 4, bits_of(kb, 4), -64'sd2147483648);
        chk("R5", "token 5 unaffected", res_psum, exp_psum(kb, 4));
    endtask

    task automatic t_extreme();
        for (int i = 0; i < 16; i++) begin q[i] = -12'sd2048; ka[i] = -12'sd2048; end
        load_query();
        run_token("R10", 6, ka);
        chk("R10", "min*min dot", res_psum, 64'sd67108864);
        for (int i = 0; i < 16; i++) begin q[i] = 12'sd2047; kb[i] = 12'sd2047; end
        load_query();
        send(7, 0, bits_of(kb, 0), -64'sd2147483648);
        chk("R10", "round0 upper", res_upper, 64'sd16 * 2047 * 2047);
        run_token("R10", 7, kb);
        for (int i = 0; i < 16; i++) kb[i] = -12'sd2048;
        send(7, 0, bits_of(kb, 0), -64'sd2147483648);
        chk("R10", "max*min round0", res_psum, -64'sd16 * 2047 * 2048);
    endtask

    task automatic t_handshake();
        longint first;
        for (int i = 0; i < 16; i++) begin q[i] = 12'(i * 311 - 900); ka[i] = 12'(i * 977 + 3); end
        load_query();
        @(negedge clk);
        plane_valid = 1'b1; plane_bits = 16'h00FF; plane_token = 3'd1;
        plane_round = 4'd0; threshold = -32'sd2147483648;
        @(posedge clk);
        @(negedge clk);
        chk("R2", "valid after accept", res_valid, 1);
        chk("R2", "ready low in report", plane_ready, 0);
        first = res_psum;
        plane_bits = 16'hFF00;
        @(negedge clk);
        chk("R2", "valid one cycle", res_valid, 0);
        chk("R2", "result held", res_psum, first);
        plane_valid = 1'b0;
        send(1, 1, 16'h0000, -64'sd2147483648);
        chk("R2", "no double accept", res_psum, first);
    endtask

    initial begin
        t_reset();
        t_full_keep();
        t_prune_high();
        t_threshold_edge();
        t_interleave();
        t_extreme();
        t_handshake();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule